// File: doc/BRIEF.md
# Byte-Wide Configuration Stream Loader

This block takes a configuration stream one byte at a time. A byte is present whenever the shared strobe is high on a clock edge. The block first checks a fixed seven-byte header. Every device in a chain sees the same strobe and data, so all of them take in the header together. After the header, the device loads a fixed number of frames, but only while its own chip-select is high. Each frame holds one start marker, a parameterised number of data bytes and one check byte. Each data byte appears, with its linear frame address, on a one-cycle frame-write output.

When the check byte of the final frame is accepted, the pass-through output goes high and stays high. In a chain this output drives the chip-select of the next device. Any byte after that is a don't-care start-up byte, and each one advances a saturating counter.

If a header byte, start marker or check byte is wrong, the block stops loading. It then holds its active-low error output low until reset, and reset also serves as the program pulse. The stream has no length count and no CRC.

Byte values below are written as `cfg_din` hexadecimal values, with D0 = `cfg_din[0]`. A pattern whose D0 is written first, such as 11110010, therefore reads as 0x4F.

Top module: `cfg_stream_loader`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to the first header byte. From the next cycle `init_n` is 1, and `chain_out`, `fw_en` and `startup_cnt` are 0.
- R2: The header is the bytes 0xFF, 0xFF, 0x4F, 0xFF, 0xFF, 0xFF, 0x4B in that order. A header byte is taken on every edge with `cfg_stb` high, whatever the level of `cfg_cs`.
- R3: Once the header is done, a byte is taken only on an edge with both `cfg_stb` and `cfg_cs` high. An edge with `cfg_cs` low changes no output and does not move the frame position.
- R4: Each frame must open with the start byte 0x7F. Any other first byte is a format error.
- R5: A taken data byte sets `fw_en` high for exactly the next cycle. `fw_data` then equals that byte and `fw_addr` equals frame × FRAME_BYTES + byte index, both counted from zero.
- R6: After FRAME_BYTES data bytes, the next taken byte must be the check byte 0x4B. Any other value is a format error.
- R7: A header byte that differs from the value R2 expects for its position is a format error.
- R8: From the cycle after a format error, `init_n` is 0 until reset. While it is 0, `fw_en` and `chain_out` stay 0 and `startup_cnt` does not change.
- R9: From the cycle after the correct check byte of frame NUM_FRAMES-1 is taken, `chain_out` is 1 until reset.
- R10: While `chain_out` is 1, each taken byte adds one to `startup_cnt`, whatever its value. The count saturates at 2^SU_W-1.
- R11: A reset in the middle of a load, or after an error, discards all progress. A complete, correct stream is then accepted again from its first header byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset; also starts a new configuration |
| cfg_cs | input | 1 | Chip-select; qualifies frame and start-up bytes |
| cfg_stb | input | 1 | A stream byte is present on this edge |
| cfg_din | input | 8 | Stream byte, D0 in bit 0 |
| fw_en | output | 1 | Frame data byte valid, one cycle |
| fw_data | output | 8 | Frame data byte |
| fw_addr | output | ADDR_W | Linear frame byte address |
| chain_out | output | 1 | High once all frames are loaded; enables the next device |
| init_n | output | 1 | Low after a format error, until reset |
| startup_cnt | output | SU_W | Saturating count of start-up bytes |

## Verification
If the block lost its place in the stream, the fault would show at the ports within a byte or two. A slipped byte counter moves `fw_addr` on the next write, and it also makes a data byte land where the check byte is expected, so `init_n` falls at the end of the frame. A frame counter that is off by one makes `chain_out` rise one frame early or one frame late. A state that ignores `cfg_cs` writes data during cycles that should be idle. The bench runs a behavioural model next to the design and compares every output on every cycle. Each of these faults is therefore caught in the cycle where it first becomes visible.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam logic [7:0] PREAMBLE    = 8'h4F;
  localparam logic [7:0] HDR_CHECK   = 8'h4B;
  localparam logic [7:0] FRAME_START = 8'h7F;
  localparam logic [7:0] FRAME_CHECK = 8'h4B;
  localparam int         HDR_LEN     = 7;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_START,
    ST_DATA,
    ST_CHECK,
    ST_DONE,
    ST_FAULT
  } ld_state_e;

  // Expected header byte at a given header position
  function automatic logic [7:0] hdr_expect(input logic [2:0] idx);
    case (idx)
      3'd2:    hdr_expect = PREAMBLE;
      3'd6:    hdr_expect = HDR_CHECK;
      default: hdr_expect = FILL_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/cfg_idx_ctr.sv
module cfg_idx_ctr #(
  parameter int MAX = 4,
  localparam int W  = (MAX > 1) ? $clog2(MAX) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         last
);

  assign last = (cnt == W'(MAX - 1));

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= last ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/cfg_byte_match.sv
module cfg_byte_match
  import cfg_loader_pkg::*;
(
  input  ld_state_e  state,
  input  logic [2:0] hdr_idx,
  input  logic [7:0] din,
  output logic       ok
);

  always_comb begin
    case (state)
      ST_HDR:   ok = (din == hdr_expect(hdr_idx));
      ST_START: ok = (din == FRAME_START);
      ST_CHECK: ok = (din == FRAME_CHECK);
      default:  ok = 1'b1;
    endcase
  end

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_loader_pkg::*;
#(
  parameter int NUM_FRAMES  = 4,
  parameter int FRAME_BYTES = 4,
  parameter int SU_W        = 4,
  localparam int ADDR_W     = (NUM_FRAMES * FRAME_BYTES > 1) ? $clog2(NUM_FRAMES * FRAME_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cs,
  input  logic              cfg_stb,
  input  logic [7:0]        cfg_din,
  output logic              fw_en,
  output logic [7:0]        fw_data,
  output logic [ADDR_W-1:0] fw_addr,
  output logic              chain_out,
  output logic              init_n,
  output logic [SU_W-1:0]   startup_cnt
);

  localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam int BW = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;

  ld_state_e state_q, state_d;

  logic [2:0]    hdr_idx;
  logic [FW-1:0] frm_idx;
  logic [BW-1:0] byte_idx;
  logic          hdr_last, frm_last, byte_last;
  logic          hdr_inc, frm_inc, byte_inc;
  logic          byte_ok;
  logic          take_hdr, take_frm;
  logic          wr_d;

  cfg_idx_ctr #(.MAX(HDR_LEN)) u_hdr_ctr (
    .clk(clk), .rst(rst), .inc(hdr_inc), .cnt(hdr_idx), .last(hdr_last)
  );

  cfg_idx_ctr #(.MAX(NUM_FRAMES)) u_frm_ctr (
    .clk(clk), .rst(rst), .inc(frm_inc), .cnt(frm_idx), .last(frm_last)
  );

  cfg_idx_ctr #(.MAX(FRAME_BYTES)) u_byte_ctr (
    .clk(clk), .rst(rst), .inc(byte_inc), .cnt(byte_idx), .last(byte_last)
  );

  cfg_byte_match u_match (
    .state(state_q), .hdr_idx(hdr_idx), .din(cfg_din), .ok(byte_ok)
  );

  // Header is shared by the whole chain; frames need chip-select
  assign take_hdr = cfg_stb && (state_q == ST_HDR);
  assign take_frm = cfg_stb && cfg_cs;

  always_comb begin
    state_d  = state_q;
    hdr_inc  = 1'b0;
    frm_inc  = 1'b0;
    byte_inc = 1'b0;
    wr_d     = 1'b0;
    case (state_q)
      ST_HDR: if (take_hdr) begin
        if (!byte_ok)      state_d = ST_FAULT;
        else begin
          hdr_inc = 1'b1;
          if (hdr_last)    state_d = ST_START;
        end
      end
      ST_START: if (take_frm) begin
        state_d = byte_ok ? ST_DATA : ST_FAULT;
      end
      ST_DATA: if (take_frm) begin
        wr_d     = 1'b1;
        byte_inc = 1'b1;
        if (byte_last)     state_d = ST_CHECK;
      end
      ST_CHECK: if (take_frm) begin
        if (!byte_ok)      state_d = ST_FAULT;
        else begin
          frm_inc = 1'b1;
          state_d = frm_last ? ST_DONE : ST_START;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_HDR;
      fw_en       <= 1'b0;
      fw_data     <= '0;
      fw_addr     <= '0;
      chain_out   <= 1'b0;
      init_n      <= 1'b1;
      startup_cnt <= '0;
    end else begin
      state_q   <= state_d;
      fw_en     <= wr_d;
      if (wr_d) begin
        fw_data <= cfg_din;
        fw_addr <= ADDR_W'(int'(frm_idx) * FRAME_BYTES + int'(byte_idx));
      end
      chain_out <= (state_d == ST_DONE);
      init_n    <= (state_d != ST_FAULT);
      if (state_q == ST_DONE && take_frm && startup_cnt != {SU_W{1'b1}})
        startup_cnt <= startup_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk #(
  parameter int SU_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_cs,
  input logic            cfg_stb,
  input logic            fw_en,
  input logic            chain_out,
  input logic            init_n,
  input logic [SU_W-1:0] startup_cnt
);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    !init_n |=> !init_n); // R8

  AST_NO_WR_IN_ERR: assert property (@(posedge clk) disable iff (rst)
    !init_n |-> (!fw_en && !chain_out)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    chain_out |=> chain_out); // R9

  AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    fw_en |-> ($past(cfg_cs) && $past(cfg_stb))); // R3

  AST_STARTUP_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(startup_cnt) |-> (chain_out && $past(cfg_cs) && $past(cfg_stb))); // R10

  AST_NO_WR_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    chain_out |-> !fw_en); // R9

endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(.SU_W(SU_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_cs(cfg_cs), .cfg_stb(cfg_stb), .fw_en(fw_en),
  .chain_out(chain_out), .init_n(init_n), .startup_cnt(startup_cnt)
);

// File: tb/cfg_stream_loader_tb.sv
module cfg_stream_loader_tb;

  localparam int NF = 4;
  localparam int FB = 4;
  localparam int SW = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs  = 1'b0;
  logic          stb = 1'b0;
  logic [7:0]    din = 8'h00;
  logic          fw_en, chain_out, init_n;
  logic [7:0]    fw_data;
  logic [AW-1:0] fw_addr;
  logic [SW-1:0] startup_cnt;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int m_state, m_hidx, m_fidx, m_bidx, m_we, m_wdata, m_waddr, m_dout, m_initn, m_su;
  int hdr_bytes[7] = '{8'hFF, 8'hFF, 8'h4F, 8'hFF, 8'hFF, 8'hFF, 8'h4B};

  always #2 clk = ~clk;

  cfg_stream_loader u_dut (
    .clk(clk), .rst(rst), .cfg_cs(cs), .cfg_stb(stb), .cfg_din(din),
    .fw_en(fw_en), .fw_data(fw_data), .fw_addr(fw_addr),
    .chain_out(chain_out), .init_n(init_n), .startup_cnt(startup_cnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    m_we = 0;
    if (rst) begin
      m_state = 0; m_hidx = 0; m_fidx = 0; m_bidx = 0;
      m_wdata = 0; m_waddr = 0; m_su = 0;
    end else begin
      case (m_state)
        0: if (stb) begin
          if (int'(din) != hdr_bytes[m_hidx]) m_state = 5;
          else if (m_hidx == 6) begin m_hidx = 0; m_state = 1; end
          else m_hidx++;
        end
        1: if (stb && cs) m_state = (din == 8'h7F) ? 2 : 5;
        2: if (stb && cs) begin
          m_we = 1; m_wdata = din; m_waddr = m_fidx * FB + m_bidx;
          if (m_bidx == FB - 1) begin m_bidx = 0; m_state = 3; end
          else m_bidx++;
        end
        3: if (stb && cs) begin
          if (din != 8'h4B) m_state = 5;
          else if (m_fidx == NF - 1) m_state = 4;
          else begin m_fidx++; m_state = 1; end
        end
        4: if (stb && cs && m_su < (1 << SW) - 1) m_su++;
        default: ;
      endcase
    end
    m_dout  = (m_state == 4);
    m_initn = (m_state != 5);
  endtask

  task automatic compare();
    check(fw_en == m_we, "R5 fw_en", fw_en, m_we);
    if (m_we != 0) begin
      check(fw_data == m_wdata, "R5 fw_data", fw_data, m_wdata);
      check(fw_addr == m_waddr, "R5 fw_addr", fw_addr, m_waddr);
    end
    check(init_n == m_initn, "R8 init_n", init_n, m_initn);
    check(chain_out == m_dout, "R9 chain_out", chain_out, m_dout);
    check(startup_cnt == m_su, "R10 startup_cnt", startup_cnt, m_su);
  endtask

  task automatic step(input bit s, input bit c, input logic [7:0] d);
    stb = s; cs = c; din = d;
    @(posedge clk);
    model_update();
    #1;
    compare();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, 0, 8'h00);
    step(0, 0, 8'h00);
    rst = 1'b0;
  endtask

  task automatic send_header(input bit c);
    for (int i = 0; i < 7; i++) step(1, c, 8'(hdr_bytes[i]));
  endtask

  task automatic send_frame(input int f);
    step(1, 1, 8'h7F);
    for (int b = 0; b < FB; b++) begin
      step(1, 1, 8'(f * 16 + b + 1));
      if (b == 1) step(1, 0, 8'hA5); // R3: byte without chip-select
      if (b == 2) step(0, 1, 8'h5A); // R3: no strobe
    end
    step(1, 1, 8'h4B);
  endtask

  initial begin
    m_state = 0; m_hidx = 0; m_fidx = 0; m_bidx = 0; m_we = 0;
    m_wdata = 0; m_waddr = 0; m_dout = 0; m_initn = 1; m_su = 0;
    do_reset();
    // R1 reset state
    check(init_n == 1 && chain_out == 0 && fw_en == 0 && startup_cnt == 0,
          "R1 reset outputs", {init_n, chain_out, fw_en}, 3'b100);

    // Clean load: header with chip-select low (R2), frames with it high
    send_header(0);
    check(init_n == 1, "R2 header accepted without cs", init_n, 1);
    step(1, 0, 8'h7F); // R3: start byte ignored while cs low
    check(init_n == 1, "R3 cs-low byte ignored", init_n, 1);
    for (int f = 0; f < NF; f++) begin
      send_frame(f);
      if (f < NF - 1) check(chain_out == 0, "R9 not early", chain_out, 0);
    end
    check(chain_out == 1, "R9 chain_out after last frame", chain_out, 1);
    step(1, 0, 8'h12); // R10: needs cs
    for (int i = 0; i < 18; i++) step(1, 1, 8'(i * 7));
    check(startup_cnt == 4'hF, "R10 saturation", startup_cnt, 4'hF);

    // R7: bad preamble
    do_reset();
    step(1, 0, 8'hFF); step(1, 0, 8'hFF); step(1, 0, 8'hF2);
    check(init_n == 0, "R7 header mismatch", init_n, 0);
    send_header(1);
    step(1, 1, 8'h7F); step(1, 1, 8'h01);
    check(init_n == 0 && fw_en == 0, "R8 held after error", {init_n, fw_en}, 0);

    // R4: bad start byte
    do_reset();
    send_header(1);
    step(1, 1, 8'hFE);
    check(init_n == 0, "R4 bad start", init_n, 0);
    step(1, 1, 8'h03);
    check(fw_en == 0, "R4 no write after bad start", fw_en, 0);

    // R6: bad check byte, then nothing more loads
    do_reset();
    send_header(1);
    step(1, 1, 8'h7F);
    for (int b = 0; b < FB; b++) step(1, 1, 8'(b + 8'h40));
    step(1, 1, 8'hD2);
    check(init_n == 0, "R6 bad check", init_n, 0);
    send_frame(1);

    // R11: reset mid-load, then a full load
    do_reset();
    send_header(1);
    step(1, 1, 8'h7F); step(1, 1, 8'h77);
    do_reset();
    check(init_n == 1 && chain_out == 0, "R11 reset clears", {init_n, chain_out}, 2'b10);
    send_header(1);
    for (int f = 0; f < NF; f++) send_frame(f);
    check(chain_out == 1 && init_n == 1, "R11 reload completes", {chain_out, init_n}, 2'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule